// File: doc/BRIEF.md
# Dual-Port Microcode RAM Controller

This block owns a word-wide RAM array that can be filled and read over a host bus slave port. The same array can instead be lent to two coprocessor engines, which fetch microcode through two read-only auxiliary ports. An engine takes the array by raising its emulation request. While any request is high, the host loses all access to the array, and each requesting engine reads one word per cycle from its own port.

A single configuration register holds a stop bit and an array-disable bit. Setting stop puts the block in its low-power state. In that state the host cannot reach the array and the contents are kept unchanged. The register port keeps working so that stop can be cleared again. The block refuses to enter stop while an engine owns the array. A freeze input is accepted and has no effect. A host access that cannot be served completes with an error response one cycle later, so it never hangs.

Top module: `ucram_ctrl`

## Requirements
- R1: After reset the stop bit and the disable bit are 0, a read of the configuration register (register offset 0) returns 0, and the acknowledge, error, read-data and auxiliary data outputs are all 0.
- R2: With stop and disable both 0 and no emulation request, a host array access is acknowledged in the cycle after the request. A read returns the word last written to that address.
- R3: Writing 1 to bit 0 of the configuration register sets stop. While stop is set, host array accesses get an error response and writes are dropped. After stop clears, the array still holds its earlier contents.
- R4: While stop is set, a configuration write changes only the stop bit (bit 0), and the disable bit (bit 1) keeps its value. A configuration read returns only the stop bit. Reads of any register offset other than 0 return 0 at all times.
- R5: With the disable bit (bit 1) set, host array accesses get an error response and have no effect on the array.
- R6: While either emulation request is high, every host array access gets an error response, and writes do not reach the array.
- R7: A configuration write that sets stop is refused while either emulation request is high, and stop stays 0.
- R8: Each auxiliary port whose emulation request is high returns the array word at its address one cycle later. Both ports can read different addresses in the same cycle.
- R9: An auxiliary port whose emulation request is low holds its data output unchanged.
- R10: The freeze input has no effect on host accesses or on auxiliary fetches.
- R11: Host register accesses are always acknowledged in the next cycle and never produce an error, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freeze_i | input | 1 | Freeze indication, has no effect |
| host_req_i | input | 1 | Host access request, one cycle per access |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_reg_i | input | 1 | 1 = register space, 0 = array space |
| host_addr_i | input | ADDR_W | Word address or register offset |
| host_wdata_i | input | DATA_W | Write data |
| host_ack_o | output | 1 | Access completed, one cycle after the request |
| host_err_o | output | 1 | Access refused, one cycle after the request |
| host_rdata_o | output | DATA_W | Read data, valid together with the acknowledge |
| emu_req_i | input | 2 | Emulation request per engine (bit k = engine k) |
| aux0_addr_i | input | ADDR_W | Fetch address, engine 0 |
| aux1_addr_i | input | ADDR_W | Fetch address, engine 1 |
| aux0_data_o | output | DATA_W | Fetched word, engine 0 |
| aux1_data_o | output | DATA_W | Fetched word, engine 1 |

## Verification
The hardest states to reach are the ones where two controls are in effect at the same time. One is a configuration write that would set stop while an engine holds the array. The other is a configuration write of both bits while the block is already stopped. The stimulus table builds each state in order, from the ports alone. It first fills known words into the array. It then enters stop and tries writes that must be dropped, then clears stop and reads back those same words. An emulation request is raised together with a stop write, and the configuration is then read back to confirm the refusal.

// File: rtl/ucram_pkg.sv
package ucram_pkg;
  localparam int unsigned N_AUX = 2;
  localparam int unsigned STOP_BIT = 0;
  localparam int unsigned DIS_BIT  = 1;
endpackage

// File: rtl/ucram_cfg_regs.sv
module ucram_cfg_regs (
  input  logic clk,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic wstop_i,
  input  logic wdis_i,
  input  logic emu_any_i,
  output logic stop_o,
  output logic dis_o
);
  logic stop_q, stop_d, dis_q, dis_d;

  always_comb begin
    stop_d = stop_q;
    dis_d  = dis_q;
    if (cfg_wr_i) begin
      if (stop_q) begin
        stop_d = wstop_i;
      end else begin
        stop_d = wstop_i & ~emu_any_i;
        dis_d  = wdis_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      dis_q  <= 1'b0;
    end else if (cfg_wr_i) begin
      stop_q <= stop_d;
      dis_q  <= dis_d;
    end
  end

  assign stop_o = stop_q;
  assign dis_o  = dis_q;

  p_stop_refused_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_wr_i && wstop_i && emu_any_i && !stop_q) |=> !stop_q);
  p_dis_kept_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_wr_i && stop_q) |=> $stable(dis_q));
endmodule

// File: rtl/ucram_access_gate.sv
module ucram_access_gate #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              is_reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stop_i,
  input  logic              dis_i,
  input  logic              emu_any_i,
  output logic              cfg_wr_o,
  output logic              arr_we_o,
  output logic              arr_re_o,
  output logic              ack_o,
  output logic              err_o,
  output logic              rd_arr_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  import ucram_pkg::*;

  logic              grant, cfg_hit, arr_req;
  logic              ack_d, err_d, rd_arr_d;
  logic [DATA_W-1:0] reg_d;
  logic              ack_q, err_q, rd_arr_q;
  logic [DATA_W-1:0] reg_q;

  always_comb begin
    grant    = ~stop_i & ~dis_i & ~emu_any_i;
    cfg_hit  = req_i & is_reg_i & (addr_i == '0);
    arr_req  = req_i & ~is_reg_i;
    cfg_wr_o = cfg_hit & wr_i;
    arr_we_o = arr_req & wr_i & grant;
    arr_re_o = arr_req & ~wr_i & grant;
    ack_d    = (req_i & is_reg_i) | (arr_req & grant);
    err_d    = arr_req & ~grant;
    rd_arr_d = arr_re_o;
    reg_d    = '0;
    if (cfg_hit && !wr_i) begin
      reg_d[STOP_BIT] = stop_i;
      reg_d[DIS_BIT]  = dis_i & ~stop_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
      rd_arr_q <= 1'b0;
      reg_q    <= '0;
    end else begin
      ack_q    <= ack_d;
      err_q    <= err_d;
      rd_arr_q <= rd_arr_d;
      reg_q    <= reg_d;
    end
  end

  assign ack_o       = ack_q;
  assign err_o       = err_q;
  assign rd_arr_o    = rd_arr_q;
  assign reg_rdata_o = reg_q;

  p_emu_blocks_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && !is_reg_i && emu_any_i) |=> (err_o && !ack_o));
  p_stop_blocks_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && !is_reg_i && stop_i) |=> (err_o && !ack_o));
  p_reg_ack_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && is_reg_i) |=> (ack_o && !err_o));
endmodule

// File: rtl/ucram_array.sv
module ucram_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_PORT = 2
) (
  input  logic                           clk,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic                           re_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic [N_PORT-1:0]              aux_en_i,
  input  logic [N_PORT-1:0][ADDR_W-1:0]  aux_addr_i,
  output logic [N_PORT-1:0][DATA_W-1:0]  aux_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[addr_i];
  end
  assign rdata_o = rdata_q;

  for (genvar k = 0; k < N_PORT; k++) begin : g_aux
    logic [DATA_W-1:0] data_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)            data_q <= '0;
      else if (aux_en_i[k])   data_q <= mem_q[aux_addr_i[k]];
    end
    assign aux_data_o[k] = data_q;

    p_aux_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
      !aux_en_i[k] |=> $stable(aux_data_o[k]));
  end
endmodule

// File: rtl/ucram_ctrl.sv
module ucram_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              host_req_i,
  input  logic              host_wr_i,
  input  logic              host_reg_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              host_ack_o,
  output logic              host_err_o,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic [1:0]        emu_req_i,
  input  logic [ADDR_W-1:0] aux0_addr_i,
  input  logic [ADDR_W-1:0] aux1_addr_i,
  output logic [DATA_W-1:0] aux0_data_o,
  output logic [DATA_W-1:0] aux1_data_o
);
  import ucram_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic                          emu_any, stop, dis, cfg_wr;
  logic                          arr_we, arr_re, rd_arr;
  logic [DATA_W-1:0]             reg_rdata, arr_rdata;
  logic [N_AUX-1:0][ADDR_W-1:0]  aux_addr;
  logic [N_AUX-1:0][DATA_W-1:0]  aux_data;

  assign emu_any  = |emu_req_i;
  assign aux_addr = {aux1_addr_i, aux0_addr_i};

  ucram_cfg_regs u_cfg (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (cfg_wr),
    .wstop_i   (host_wdata_i[STOP_BIT]),
    .wdis_i    (host_wdata_i[DIS_BIT]),
    .emu_any_i (emu_any),
    .stop_o    (stop),
    .dis_o     (dis)
  );

  ucram_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .req_i       (host_req_i),
    .wr_i        (host_wr_i),
    .is_reg_i    (host_reg_i),
    .addr_i      (host_addr_i),
    .stop_i      (stop),
    .dis_i       (dis),
    .emu_any_i   (emu_any),
    .cfg_wr_o    (cfg_wr),
    .arr_we_o    (arr_we),
    .arr_re_o    (arr_re),
    .ack_o       (host_ack_o),
    .err_o       (host_err_o),
    .rd_arr_o    (rd_arr),
    .reg_rdata_o (reg_rdata)
  );

  ucram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PORT(N_AUX)) u_array (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .we_i       (arr_we),
    .re_i       (arr_re),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (arr_rdata),
    .aux_en_i   (emu_req_i),
    .aux_addr_i (aux_addr),
    .aux_data_o (aux_data)
  );

  assign host_rdata_o = rd_arr ? arr_rdata : reg_rdata;
  assign aux0_data_o  = aux_data[0];
  assign aux1_data_o  = aux_data[1];

  p_write_granted_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    arr_we |-> (!dis && !stop && !emu_any));
  p_freeze_ignored_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (freeze_i && host_req_i && !host_reg_i && !dis && !stop && !emu_any)
      |=> (host_ack_o && !host_err_o));
endmodule

// File: tb/ucram_ctrl_tb_top.sv
module ucram_ctrl_tb_top;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          freeze = 1'b0;
  logic          req = 1'b0, wr = 1'b0, isreg = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack, err;
  logic [DW-1:0] rdata;
  logic [1:0]    emu = 2'b00;
  logic [AW-1:0] a0 = '0, a1 = '0;
  logic [DW-1:0] d0, d1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ucram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze),
    .host_req_i(req), .host_wr_i(wr), .host_reg_i(isreg),
    .host_addr_i(addr), .host_wdata_i(wdata),
    .host_ack_o(ack), .host_err_o(err), .host_rdata_o(rdata),
    .emu_req_i(emu), .aux0_addr_i(a0), .aux1_addr_i(a1),
    .aux0_data_o(d0), .aux1_data_o(d1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; isreg = r; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  typedef struct packed {
    logic          is_reg;
    logic          wr;
    logic [1:0]    emu;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          ack;
    logic          err;
    logic          chk_data;
    logic [DW-1:0] data;
    logic [3:0]    req_no;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,2'b00,8'h05,16'h1234,1'b1,1'b0,1'b0,16'h0000,4'd2},  // R2 write
    '{1'b0,1'b1,2'b00,8'h09,16'hBEEF,1'b1,1'b0,1'b0,16'h0000,4'd2},  // R2 write
    '{1'b0,1'b0,2'b00,8'h05,16'h0000,1'b1,1'b0,1'b1,16'h1234,4'd2},  // R2 read
    '{1'b1,1'b0,2'b00,8'h00,16'h0000,1'b1,1'b0,1'b1,16'h0000,4'd11}, // R11
    '{1'b1,1'b1,2'b00,8'h00,16'h0002,1'b1,1'b0,1'b0,16'h0000,4'd11}, // set disable
    '{1'b0,1'b1,2'b00,8'h05,16'h0000,1'b0,1'b1,1'b0,16'h0000,4'd5},  // R5
    '{1'b0,1'b0,2'b00,8'h05,16'h0000,1'b0,1'b1,1'b0,16'h0000,4'd5},  // R5
    '{1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd5},  // clear
    '{1'b0,1'b0,2'b00,8'h05,16'h0000,1'b1,1'b0,1'b1,16'h1234,4'd5},  // R5 dropped
    '{1'b1,1'b1,2'b00,8'h00,16'h0001,1'b1,1'b0,1'b0,16'h0000,4'd3},  // R3 stop
    '{1'b0,1'b0,2'b00,8'h09,16'h0000,1'b0,1'b1,1'b0,16'h0000,4'd3},  // R3
    '{1'b0,1'b1,2'b00,8'h09,16'h0000,1'b0,1'b1,1'b0,16'h0000,4'd3},  // R3
    '{1'b1,1'b1,2'b00,8'h00,16'h0003,1'b1,1'b0,1'b0,16'h0000,4'd4},  // R4
    '{1'b1,1'b0,2'b00,8'h00,16'h0000,1'b1,1'b0,1'b1,16'h0001,4'd4},  // R4
    '{1'b1,1'b0,2'b00,8'h03,16'h0000,1'b1,1'b0,1'b1,16'h0000,4'd4},  // R4
    '{1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd4},  // clear stop
    '{1'b1,1'b0,2'b00,8'h00,16'h0000,1'b1,1'b0,1'b1,16'h0000,4'd4},  // R4 dis kept 0
    '{1'b0,1'b0,2'b00,8'h09,16'h0000,1'b1,1'b0,1'b1,16'hBEEF,4'd3},  // R3 retained
    '{1'b0,1'b1,2'b01,8'h09,16'h0001,1'b0,1'b1,1'b0,16'h0000,4'd6},  // R6
    '{1'b1,1'b1,2'b10,8'h00,16'h0001,1'b1,1'b0,1'b0,16'h0000,4'd7},  // R7
    '{1'b1,1'b0,2'b10,8'h00,16'h0000,1'b1,1'b0,1'b1,16'h0000,4'd7},  // R7
    '{1'b0,1'b0,2'b00,8'h09,16'h0000,1'b1,1'b0,1'b1,16'hBEEF,4'd6}   // R6 dropped
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 ack", ack, 0);
    chk("R1 err", err, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 aux0", d0, 0);
    chk("R1 aux1", d1, 0);
    host(1'b1, 1'b0, 8'h00, 16'h0);
    chk("R1 cfg", rdata, 0);

    for (int i = 0; i < NV; i++) begin
      emu = VECS[i].emu;
      host(VECS[i].is_reg, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      chk($sformatf("R%0d vec%0d ack", VECS[i].req_no, i), ack, VECS[i].ack);
      chk($sformatf("R%0d vec%0d err", VECS[i].req_no, i), err, VECS[i].err);
      if (VECS[i].chk_data)
        chk($sformatf("R%0d vec%0d data", VECS[i].req_no, i), rdata, VECS[i].data);
    end
    emu = 2'b00;

    // R8: both ports fetch in the same cycle
    @(negedge clk);
    emu = 2'b11; a0 = 8'h05; a1 = 8'h09;
    @(negedge clk);
    chk("R8 aux0", d0, 16'h1234);
    chk("R8 aux1", d1, 16'hBEEF);

    // R9: port 1 not requesting holds its output
    emu = 2'b01; a0 = 8'h09; a1 = 8'h05;
    @(negedge clk);
    chk("R8 aux0 new addr", d0, 16'hBEEF);
    chk("R9 aux1 held", d1, 16'hBEEF);
    emu = 2'b00;

    // R10: freeze has no effect
    freeze = 1'b1;
    host(1'b0, 1'b1, 8'h14, 16'h0007);
    chk("R10 write ack", ack, 1);
    host(1'b0, 1'b0, 8'h14, 16'h0);
    chk("R10 read data", rdata, 16'h0007);
    @(negedge clk);
    emu = 2'b10; a1 = 8'h14;
    @(negedge clk);
    chk("R10 aux1 fetch", d1, 16'h0007);
    emu = 2'b00;
    freeze = 1'b0;

    // R11: register access during emulation and during stop
    emu = 2'b01;
    host(1'b1, 1'b0, 8'h07, 16'h0);
    chk("R11 ack emu", ack, 1);
    chk("R11 no err emu", err, 0);
    emu = 2'b00;
    host(1'b1, 1'b1, 8'h00, 16'h0001);
    host(1'b1, 1'b0, 8'h00, 16'h0);
    chk("R11 ack stopped", ack, 1);
    chk("R3 stop set", rdata, 16'h0001);

    // R1: reset pulse clears stop
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    host(1'b1, 1'b0, 8'h00, 16'h0);
    chk("R1 stop cleared by reset", rdata, 0);
    host(1'b0, 1'b0, 8'h14, 16'h0);
    chk("R1 array usable after reset", ack, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule